// File: doc/BRIEF.md
# Byte/Word Load-Store Alignment Unit

This block sits between a 16-bit memory data register and a byte-addressable memory organised as one word of two byte lanes. On the load side it takes the word read from memory and hands the data bus either that word unchanged or one of its bytes. The byte is chosen by address bit 0 and sign-extended to the full width. On the store side it builds the word to be written and drives one write enable for each byte lane. The lanes it enables depend on the read/write control, the access size, address bit 0 and a memory-enable input.

The unit is purely combinational. A word access at an odd address cannot be carried out. It blocks both lane enables and raises an error output, and it takes no further action. The width is a parameter and must be even. The lower half is the even-address lane and the upper half is the odd-address lane.

Top module: `lsalign`

## Requirements
- R1: With size_word=0 and addr_lsb=0, load_out is data bits [7:0] of mdr_rd sign-extended to 16 bits (bit 7 copied into bits [15:8]).
- R2: With size_word=0 and addr_lsb=1, load_out is bits [15:8] of mdr_rd sign-extended to 16 bits (bit 15 copied into bits [15:8]).
- R3: With size_word=1, load_out equals mdr_rd unchanged, whatever the value of addr_lsb.
- R4: store_data equals src_data when addr_lsb=0. When addr_lsb=1 it is {src_data[7:0], src_data[7:0]}.
- R5: Neither we_hi nor we_lo is 1 unless mem_en=1 and wr=1 (wr=1 means write, wr=0 means read).
- R6: A byte write (mem_en=1, wr=1, size_word=0) asserts only we_lo when addr_lsb=0 and only we_hi when addr_lsb=1. we_hi enables bits [15:8] and we_lo enables bits [7:0].
- R7: An aligned word write (mem_en=1, wr=1, size_word=1, addr_lsb=0) asserts both we_hi and we_lo.
- R8: misalign is 1 exactly when mem_en=1, size_word=1 and addr_lsb=1, for a read or a write. While it is 1, both write enables are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mem_en | input | 1 | Memory or I/O access this cycle |
| wr | input | 1 | 1 = write, 0 = read |
| size_word | input | 1 | 1 = word access, 0 = byte access |
| addr_lsb | input | 1 | Bit 0 of the access address |
| mdr_rd | input | DW | Word held in the memory data register after a read |
| src_data | input | DW | Source register value for a store |
| load_out | output | DW | Aligned, sign-extended load value for the bus |
| store_data | output | DW | Word to load into the memory data register for a store |
| we_hi | output | 1 | Write enable for the odd-address lane, bits [15:8] |
| we_lo | output | 1 | Write enable for the even-address lane, bits [7:0] |
| misalign | output | 1 | Word access at an odd address |

## Verification
The bench tests byte loads whose selected byte has bit 7 set and bytes whose other lane holds the opposite sign. A design that takes the wrong lane, zero-extends, or extends from the wrong bit returns a wrong upper half. Byte stores at odd addresses check both the replicated store word and the one-hot lane enable. A swapped or missing replication would write the upper byte of the source, or write to both lanes. The bench also covers odd-address word accesses for reads and writes, and accesses with mem_en low. A design that does not gate the enables would corrupt memory there, and a design with a wrong error condition would flag the wrong case.

// File: rtl/lsalign.sv
module lsalign #(
  parameter int DW = 16
) (
  input  logic          mem_en,
  input  logic          wr,
  input  logic          size_word,
  input  logic          addr_lsb,
  input  logic [DW-1:0] mdr_rd,
  input  logic [DW-1:0] src_data,
  output logic [DW-1:0] load_out,
  output logic [DW-1:0] store_data,
  output logic          we_hi,
  output logic          we_lo,
  output logic          misalign
);
  localparam int HW = DW / 2;

  logic [HW-1:0] sel_byte;
  logic          wr_go;

  assign sel_byte   = addr_lsb ? mdr_rd[DW-1:HW] : mdr_rd[HW-1:0];
  assign load_out   = size_word ? mdr_rd : {{HW{sel_byte[HW-1]}}, sel_byte};

  assign store_data = addr_lsb ? {src_data[HW-1:0], src_data[HW-1:0]} : src_data;

  assign misalign   = mem_en & size_word & addr_lsb;
  assign wr_go      = mem_en & wr & ~misalign;
  assign we_lo      = wr_go & ~addr_lsb;
  assign we_hi      = wr_go & (size_word | addr_lsb);
endmodule

// File: rtl/lsalign_chk.sv
module lsalign_chk #(
  parameter int DW = 16
) (
  input logic          mem_en,
  input logic          wr,
  input logic          size_word,
  input logic          addr_lsb,
  input logic [DW-1:0] mdr_rd,
  input logic [DW-1:0] src_data,
  input logic [DW-1:0] load_out,
  input logic [DW-1:0] store_data,
  input logic          we_hi,
  input logic          we_lo,
  input logic          misalign
);
  localparam int HW = DW / 2;

  logic known;
  assign known = !$isunknown({mem_en, wr, size_word, addr_lsb, mdr_rd, src_data});

  always_comb begin
    if (known) begin
      if (!(mem_en && wr))
        a_r5_no_we_idle: assert (!we_hi && !we_lo);
      if (mem_en && wr && !size_word)
        a_r6_byte_one_lane: assert (we_hi != we_lo);
      if (mem_en && wr && size_word && !addr_lsb)
        a_r7_word_both: assert (we_hi && we_lo);
      if (misalign)
        a_r8_misalign_blocks: assert (!we_hi && !we_lo);
      if (size_word)
        a_r3_word_pass: assert (load_out == mdr_rd);
      if (!size_word)
        a_r1_sign_fill: assert (load_out[DW-1:HW] == {HW{load_out[HW-1]}});
      a_r4_low_byte_kept: assert (store_data[HW-1:0] == src_data[HW-1:0]);
    end
  end
endmodule

bind lsalign lsalign_chk #(.DW(DW)) u_chk (
  .mem_en(mem_en), .wr(wr), .size_word(size_word), .addr_lsb(addr_lsb),
  .mdr_rd(mdr_rd), .src_data(src_data), .load_out(load_out),
  .store_data(store_data), .we_hi(we_hi), .we_lo(we_lo), .misalign(misalign)
);

// File: tb/lsalign_tb.sv
module lsalign_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mem_en, wr, size_word, addr_lsb;
  logic [15:0] mdr_rd, src_data, load_out, store_data;
  logic we_hi, we_lo, misalign;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsalign #(.DW(16)) u_dut (
    .mem_en(mem_en), .wr(wr), .size_word(size_word), .addr_lsb(addr_lsb),
    .mdr_rd(mdr_rd), .src_data(src_data), .load_out(load_out),
    .store_data(store_data), .we_hi(we_hi), .we_lo(we_lo), .misalign(misalign)
  );

  // {mem_en,wr,size_word,addr_lsb}, mdr_rd, src_data, exp load, exp store, {we_hi,we_lo,misalign}
  localparam logic [70:0] VEC [NV] = '{
    {4'b1000, 16'h12F0, 16'hAAAA, 16'hFFF0, 16'hAAAA, 3'b000},
    {4'b1000, 16'h807F, 16'h0000, 16'h007F, 16'h0000, 3'b000},
    {4'b1001, 16'h8312, 16'h1234, 16'hFF83, 16'h3434, 3'b000},
    {4'b1001, 16'h7F80, 16'h0000, 16'h007F, 16'h0000, 3'b000},
    {4'b1010, 16'hBEEF, 16'h0102, 16'hBEEF, 16'h0102, 3'b000},
    {4'b1100, 16'h0000, 16'hC3A5, 16'h0000, 16'hC3A5, 3'b010},
    {4'b1101, 16'h0000, 16'hC3A5, 16'h0000, 16'hA5A5, 3'b100},
    {4'b1110, 16'h5555, 16'h9ABC, 16'h5555, 16'h9ABC, 3'b110},
    {4'b1111, 16'h5555, 16'h9ABC, 16'h5555, 16'hBCBC, 3'b001},
    {4'b1011, 16'h1234, 16'h0000, 16'h1234, 16'h0000, 3'b001},
    {4'b0110, 16'h1234, 16'h4321, 16'h1234, 16'h4321, 3'b000},
    {4'b0101, 16'h00FF, 16'h00FF, 16'h0000, 16'hFFFF, 3'b000}
  };

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] c, input logic [15:0] m, input logic [15:0] s);
    @(posedge clk);
    {mem_en, wr, size_word, addr_lsb} = c;
    mdr_rd = m;
    src_data = s;
    @(negedge clk);
  endtask

  initial begin
    mem_en = 0; wr = 0; size_word = 0; addr_lsb = 0;
    mdr_rd = '0; src_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R5", "reset enables", {13'd0, we_hi, we_lo, misalign}, 16'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [3:0] c;
      logic [15:0] m, s, el, es;
      logic [2:0] ef;
      string lt, wt;
      {c, m, s, el, es, ef} = VEC[i];
      drive(c, m, s);
      lt = c[1] ? "R3" : (c[0] ? "R2" : "R1");
      wt = !(c[3] && c[2]) ? "R5" : (c[1] && c[0]) ? "R8" : c[1] ? "R7" : "R6";
      chk(lt, "load_out", load_out, el);
      chk("R4", "store_data", store_data, es);
      chk(wt, "we_hi/we_lo", {14'd0, we_hi, we_lo}, {14'd0, ef[2:1]});
      chk("R8", "misalign", {15'd0, misalign}, {15'd0, ef[0]});
    end

    // misaligned word write with memory disabled: no error, no enables
    drive(4'b0111, 16'h0000, 16'hFFFF);
    chk("R8", "misalign when idle", {15'd0, misalign}, 16'd0);
    chk("R5", "enables when idle", {14'd0, we_hi, we_lo}, 16'd0);
    // word load at odd address still passes the word and flags error
    drive(4'b1011, 16'h80FF, 16'h0000);
    chk("R3", "misaligned word load", load_out, 16'h80FF);
    chk("R8", "misaligned read flag", {15'd0, misalign}, 16'd1);
    // byte read must not write
    drive(4'b1001, 16'hFF00, 16'h1111);
    chk("R5", "byte read enables", {14'd0, we_hi, we_lo}, 16'd0);
    chk("R2", "odd byte negative", load_out, 16'hFFFF);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule